// File: doc/BRIEF.md
# Burst-of-two double-data-rate SRAM device logic

This block is the synchronous device side of a double-data-rate static memory that moves a pair of words for every address it accepts. One clock, `clk_i`, runs at twice the rate of the main memory clock. Its rising edges alternate between the main clock's rising half (called K-rise here) and its falling half (called K-fall). The flag `k_phase_o` tells the host which edge comes next. A command is taken only on a K-rise edge. Write data is captured one word per edge. Read data returns one word per edge, together with an echo strobe pair and an output enable.

The word width is a parameter. A second parameter chooses the burst order, and it defaults from the width. In the narrow order the address LSB is ignored and the pair is always walked from its even word. In the wide order the address LSB sets which word of the pair moves first, and the counter then moves to the other word. A latency-mode input is latched with each read. It chooses whether the first word arrives one or one-and-a-half main-clock cycles after the command. The memory depth, counted in words, is a parameter.

Top module: `burst2_ddr_sram`

## Requirements
- R1: While reset is asserted and right after it is released, `data_oe_o`, `rd_valid_o`, `cq_o` and `cmd_err_o` are 0, `cqn_o` is 1 and `k_phase_o` is 0. `k_phase_o` then toggles on every `clk_i` edge. A value of 0 means the next edge is a K-rise edge.
- R2: `ld_ni`, `rw_i` (1 = read, 0 = write), `addr_i` and `dll_en_i` are sampled only on K-rise edges. A low `ld_ni` that is present only at a K-fall edge starts nothing, writes nothing and raises no flag.
- R3: A load seen at the K-rise edge directly after an accepted command is ignored. `cmd_err_o` is 1 for the one `clk_i` cycle after that edge. The ignored command produces no read output.
- R4: For a write accepted at edge n, the first word is taken from `data_i` at edge n+2 and the second word at edge n+3.
- R5: With the narrow order (WIDTH 8), the first word of a burst is word {addr[AW-1:1],0} and the second is word {addr[AW-1:1],1}. The address LSB has no effect.
- R6: With the wide order (WIDTH 18), the first word is {addr[AW-1:1],addr[0]} and the second is {addr[AW-1:1],~addr[0]}.
- R7: For a read accepted at edge n with `dll_en_i` = 0, the first word is on `data_o` after edge n+2 and the second after edge n+3.
- R8: For a read accepted at edge n with `dll_en_i` = 1, the first word is on `data_o` after edge n+3 and the second after edge n+4. The output enable stays low after edge n+2.
- R9: `data_oe_o` and `rd_valid_o` are high only during the two output words of a read, and `data_o` is 0 at all other times.
- R10: `cq_o` is 1 during the first output word and 0 during the second, and `cqn_o` is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; its edges alternate K-rise and K-fall |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dll_en_i | input | 1 | Latency mode, latched with each read: 1 gives 1.5 cycles, 0 gives 1 cycle |
| ld_ni | input | 1 | Active-low command load |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW | Word address; AW = clog2(DEPTH) |
| data_i | input | WIDTH | Write data, one word per edge |
| data_o | output | WIDTH | Read data, 0 when not enabled |
| data_oe_o | output | 1 | Output enable of the shared data lines |
| rd_valid_o | output | 1 | Marks each valid output word |
| cq_o | output | 1 | Echo strobe |
| cqn_o | output | 1 | Complement echo strobe |
| k_phase_o | output | 1 | 0 when the next edge is a K-rise edge |
| cmd_err_o | output | 1 | Pulse that marks an ignored load |

## Verification
The hardest case to reach from the ports is a load that falls exactly one K cycle after an accepted write, during that write's data beats. It has to be refused without disturbing the words that are being captured. A directed sequence places a read request in that slot and then checks that `cmd_err_o` pulses and that no output enable follows. A later read confirms that the write landed intact.

A load held only across a K-fall edge is also driven, and the memory is read back afterwards. A random mix of reads and writes, issued at the minimum command spacing with the latency mode changing from one command to the next, runs against two instances at once. One instance uses the narrow burst order and the other the wide order.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  // word index of beat b of a burst at address a
  function automatic logic [31:0] word_idx(logic [31:0] a, logic b, logic lsb_start);
    logic first;
    first = lsb_start ? a[0] : 1'b0;
    return {a[31:1], first ^ b};
  endfunction
endpackage

// File: rtl/burst2_cmd.sv
module burst2_cmd #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dll_en_i,
  output logic          k_phase_o,
  output logic          rd_acc_o,
  output logic          wr_acc_o,
  output logic [AW-1:0] addr_o,
  output logic          dll_o,
  output logic          cmd_err_o
);
  logic k_phase_q, busy_q, rd_acc_q, wr_acc_q, err_q, dll_q;
  logic [AW-1:0] addr_q;
  logic load_req, accept;

  assign load_req = !ld_ni && !k_phase_q;
  assign accept   = load_req && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_phase_q <= 1'b0;
      busy_q    <= 1'b0;
      rd_acc_q  <= 1'b0;
      wr_acc_q  <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      dll_q     <= 1'b0;
    end else begin
      k_phase_q <= ~k_phase_q;
      if (!k_phase_q) busy_q <= accept;
      rd_acc_q <= accept && rw_i;
      wr_acc_q <= accept && !rw_i;
      err_q    <= load_req && busy_q;
      if (accept) begin
        addr_q <= addr_i;
        dll_q  <= dll_en_i;
      end
    end
  end

  assign k_phase_o = k_phase_q;
  assign rd_acc_o  = rd_acc_q;
  assign wr_acc_o  = wr_acc_q;
  assign addr_o    = addr_q;
  assign dll_o     = dll_q;
  assign cmd_err_o = err_q;

  assert_acc_on_krise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc_q || wr_acc_q) |-> k_phase_q);
  assert_err_after_acc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(rd_acc_q || wr_acc_q, 2));
  assert_err_not_acc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !(rd_acc_q || wr_acc_q));
endmodule

// File: rtl/burst2_sched.sv
module burst2_sched (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_acc_i,
  input  logic wr_acc_i,
  input  logic dll_i,
  output logic rd_ld_o,
  output logic rd_beat_o,
  output logic wr_ld_o,
  output logic wr_beat_o
);
  logic [2:0] rd_sh;
  logic [1:0] wr_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sh <= '0;
      wr_sh <= '0;
    end else begin
      rd_sh <= {rd_sh[1:0], rd_acc_i};
      wr_sh <= {wr_sh[0], wr_acc_i};
    end
  end

  // half-cycle extra delay in locked-loop mode
  assign rd_ld_o   = dll_i ? (rd_sh[1] | rd_sh[2]) : (rd_sh[0] | rd_sh[1]);
  assign rd_beat_o = dll_i ? rd_sh[2] : rd_sh[1];
  assign wr_ld_o   = wr_sh[0] | wr_sh[1];
  assign wr_beat_o = wr_sh[1];

  assert_rw_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ld_o && wr_ld_o));
endmodule

// File: rtl/burst2_array.sv
module burst2_array #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    widx_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    ridx_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && (widx_i == AW'(g))) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram
  import burst2_pkg::*;
#(
  parameter int WIDTH     = 18,
  parameter int DEPTH     = 128,
  parameter bit LSB_START = (WIDTH > 9),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dll_en_i,
  input  logic             ld_ni,
  input  logic             rw_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o,
  output logic             rd_valid_o,
  output logic             cq_o,
  output logic             cqn_o,
  output logic             k_phase_o,
  output logic             cmd_err_o
);
  logic rd_acc, wr_acc, dll_q;
  logic [AW-1:0] addr_q, widx, ridx;
  logic rd_ld, rd_beat, wr_ld, wr_beat;
  logic [WIDTH-1:0] rdata, q_q;
  logic vld_q, cq_q;

  burst2_cmd #(.AW(AW)) i_cmd (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i, .dll_en_i,
    .k_phase_o, .rd_acc_o(rd_acc), .wr_acc_o(wr_acc),
    .addr_o(addr_q), .dll_o(dll_q), .cmd_err_o
  );

  burst2_sched i_sched (
    .clk_i, .rst_ni, .rd_acc_i(rd_acc), .wr_acc_i(wr_acc), .dll_i(dll_q),
    .rd_ld_o(rd_ld), .rd_beat_o(rd_beat), .wr_ld_o(wr_ld), .wr_beat_o(wr_beat)
  );

  assign widx = AW'(word_idx(32'(addr_q), wr_beat, LSB_START));
  assign ridx = AW'(word_idx(32'(addr_q), rd_beat, LSB_START));

  burst2_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_array (
    .clk_i, .we_i(wr_ld), .widx_i(widx), .wdata_i(data_i),
    .ridx_i(ridx), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      vld_q <= 1'b0;
      cq_q  <= 1'b0;
    end else begin
      vld_q <= rd_ld;
      if (rd_ld) begin
        q_q  <= rdata;
        cq_q <= ~cq_q;
      end
    end
  end

  assign data_o     = vld_q ? q_q : '0;
  assign data_oe_o  = vld_q;
  assign rd_valid_o = vld_q;
  assign cq_o       = cq_q;
  assign cqn_o      = ~cq_q;

  assert_cq_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> cq_q);
  assert_burst_two_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |=> vld_q);
  assert_burst_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(vld_q)) |=> !vld_q);
  assert_cq_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> !cq_q);
endmodule

// File: tb/test_burst2_ddr_sram.sv
`timescale 1ns/1ps
module test_burst2_ddr_sram;
  localparam int DEPTH = 128;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, rw = 1'b0, dll = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0] din = '0;

  logic [17:0] q_w;  logic oe_w, vld_w, cq_w, cqn_w, ph_w, err_w;
  logic [7:0]  q_n;  logic oe_n, vld_n, cq_n, cqn_n, ph_n, err_n;

  logic [17:0] ref_w [DEPTH];
  logic [7:0]  ref_n [DEPTH];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  burst2_ddr_sram #(.WIDTH(18), .DEPTH(DEPTH)) i_burst2_ddr_sram (
    .clk_i(clk), .rst_ni(rst_n), .dll_en_i(dll), .ld_ni(ld_n), .rw_i(rw),
    .addr_i(addr), .data_i(din), .data_o(q_w), .data_oe_o(oe_w),
    .rd_valid_o(vld_w), .cq_o(cq_w), .cqn_o(cqn_w), .k_phase_o(ph_w), .cmd_err_o(err_w));

  burst2_ddr_sram #(.WIDTH(8), .DEPTH(DEPTH)) i_burst2_ddr_sram_narrow (
    .clk_i(clk), .rst_ni(rst_n), .dll_en_i(dll), .ld_ni(ld_n), .rw_i(rw),
    .addr_i(addr), .data_i(din[7:0]), .data_o(q_n), .data_oe_o(oe_n),
    .rd_valid_o(vld_n), .cq_o(cq_n), .cqn_o(cqn_n), .k_phase_o(ph_n), .cmd_err_o(err_n));

  function automatic int widx(int a, int b, bit wide);
    int first;
    first = wide ? (a & 1) : 0;
    return (a & ~1) | (first ^ b);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " oe wide"}, 32'(oe_w), 0);
    chk({tag, " oe narrow"}, 32'(oe_n), 0);
    chk({tag, " data wide"}, 32'(q_w), 0);
  endtask

  task automatic wait_k;
    while (ph_w) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [17:0] w0, input logic [17:0] w1);
    wait_k();
    ld_n = 1'b0; rw = 1'b0; addr = AW'(a); dll = 1'($urandom);
    @(negedge clk);
    ld_n = 1'b1; addr = AW'($urandom);
    chk_idle("R9 write n");
    @(negedge clk);
    din = w0;
    @(negedge clk);
    din = w1;
    chk_idle("R9 write n+2");
    @(negedge clk);
    din = 18'($urandom);
    ref_w[widx(a, 0, 1)] = w0;  ref_w[widx(a, 1, 1)] = w1;
    ref_n[widx(a, 0, 0)] = w0[7:0]; ref_n[widx(a, 1, 0)] = w1[7:0];
  endtask

  task automatic chk_beat(input int a, input int b, input string lat);
    chk({"R6 ", lat, " data wide"}, 32'(q_w), 32'(ref_w[widx(a, b, 1)]));
    chk({"R5 ", lat, " data narrow"}, 32'(q_n), 32'(ref_n[widx(a, b, 0)]));
    chk({"R9 ", lat, " valid"}, {30'd0, vld_w, oe_n}, 3);
    chk({"R10 ", lat, " strobes"}, {30'd0, cq_w, cqn_w}, (b == 0) ? 2 : 1);
  endtask

  task automatic do_read(input int a, input logic d);
    wait_k();
    ld_n = 1'b0; rw = 1'b1; addr = AW'(a); dll = d;
    @(negedge clk);
    ld_n = 1'b1; addr = AW'($urandom); dll = 1'($urandom);
    chk_idle("R9 read n");
    @(negedge clk);
    chk_idle("R9 read n+1");
    @(negedge clk);
    if (d) begin
      chk_idle("R8 read n+2");
      @(negedge clk); chk_beat(a, 0, "R8");
      @(negedge clk); chk_beat(a, 1, "R8");
    end else begin
      chk_beat(a, 0, "R7");
      @(negedge clk); chk_beat(a, 1, "R7");
    end
    @(negedge clk);
    chk_idle("R9 read end");
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    #1;
    chk("R1 reset oe", {31'd0, oe_w}, 0);
    chk("R1 reset strobes", {28'd0, vld_w, cq_w, cqn_w, err_w}, 4'b0010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {27'd0, oe_n, vld_n, cq_n, cqn_n, err_n}, 5'b00010);
    chk("R1 phase toggles", 32'(ph_w), 1);
    @(negedge clk);
    chk("R1 phase back", 32'(ph_w), 0);

    for (int a = 0; a < DEPTH; a += 2)
      do_write(a, 18'($urandom), 18'($urandom));

    // directed: both orders, both latencies, odd and even addresses
    do_write(5, 18'h2aaaa, 18'h15555);
    do_read(5, 1'b0);
    do_read(5, 1'b1);
    do_read(4, 1'b0);
    do_write(127, 18'h3ffff, 18'h00001);
    do_read(127, 1'b1);

    // R3: load on the K cycle right after an accepted write
    wait_k();
    ld_n = 1'b0; rw = 1'b0; addr = 7'd10;
    @(negedge clk);
    ld_n = 1'b1;
    @(negedge clk);
    ld_n = 1'b0; rw = 1'b1; addr = 7'd20; din = 18'h0abcd;
    @(negedge clk);
    chk("R3 err wide", 32'(err_w), 1);
    chk("R3 err narrow", 32'(err_n), 1);
    ld_n = 1'b1; din = 18'h31234;
    @(negedge clk);
    chk("R3 err clears", 32'(err_w), 0);
    din = 18'($urandom);
    ref_w[widx(10, 0, 1)] = 18'h0abcd; ref_w[widx(10, 1, 1)] = 18'h31234;
    ref_n[widx(10, 0, 0)] = 8'hcd;     ref_n[widx(10, 1, 0)] = 8'h34;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_idle("R3 ignored read no output");
    end
    do_read(10, 1'b0);
    do_read(20, 1'b1);

    // R2: load present only at a K-fall edge
    wait_k();
    @(negedge clk);
    ld_n = 1'b0; rw = 1'b0; addr = 7'd30;
    din = ~ref_w[30];
    @(negedge clk);
    ld_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R2 no err on K-fall", 32'(err_w), 0);
      chk_idle("R2 no action on K-fall");
      din = ~ref_w[30 + (i & 1)];
      @(negedge clk);
    end
    do_read(30, 1'b0);

    // random traffic at the minimum spacing allowed by the task flow
    for (int i = 0; i < 300; i++) begin
      int a;
      a = int'($urandom % DEPTH);
      if ($urandom % 2) do_write(a, 18'($urandom), 18'($urandom));
      else do_read(a, 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule